// File: doc/BRIEF.md
# Static TLB Address Translation Unit

This block sits between one bus master and the system interconnect and rewrites the master's addresses through a small, fully associative translation buffer. Software fills the buffer one entry at a time. It first writes a virtual tag into a staging register and a physical base into a second staging register. It then picks the destination slot through a lock register and fires a load strobe. Every entry maps one 16 MB super-section. The top 8 address bits are replaced and the low 24 bits pass through unchanged.

While translation is disabled, each access is forwarded untouched. Once translation is enabled, an access that matches no valid entry is a miss. An access that matches more than one valid entry is a multi-hit. Either fault records the offending virtual address, raises a status bit and holds the master. The held access is answered with an error response once software clears every pending status bit. It never reaches the interconnect. A soft reset wipes all entries and registers over a fixed number of cycles, and software polls a busy flag to see when it has finished.

Top module: `sttlb_xlat`

## Requirements
- R1: After reset every register reads 0, except the identification register at offset 0x00, which always reads 0x20. Writes to that offset are ignored.
- R2: With control bit 1 (offset 0x44) clear, an accepted access appears one cycle later with dValid=1, dAddr equal to mAddr, mDone=1 and mErr=0.
- R3: The tag staging register (0x58) and the base staging register (0x5C) read back what was written; 0x5C keeps only bits [31:20]. The lock register (0x50) keeps the slot base in bits [14:10] and the victim slot in bits [8:4]. Writing 1 to bit 0 at 0x54 loads the victim slot with tag = tag-register bits [31:24], valid = tag-register bit 3, and base = base-register bits [31:24].
- R4: With translation on, an access that hits exactly one valid entry completes one cycle later with dAddr = {entry base, mAddr[23:0]} and mErr=0.
- R5: With translation on, a miss sets status bit 0 (offset 0x18) and latches mAddr into the fault register (0x48). It asserts neither dValid nor mDone while the fault is pending.
- R6: With translation on, an access matching two or more valid entries sets status bit 4 and is held in the same way as a miss.
- R7: The irq output is high exactly when a status bit is set whose enable bit, at the same position in offset 0x1C, is also set.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. While any status bit is still set, the access stays held. The cycle after the status becomes all zero, the held access completes with mDone=1, mErr=1 and dValid=0.
- R9: Writing 1 to bit 1 at offset 0x10 starts a soft reset. Status bit 0 at offset 0x14 reads 1 for exactly RST_CYCLES cycles and then reads 0. The reset invalidates every entry, clears all registers, and accepts no access while it runs.
- R10: After a cycle with mDone=1 the unit accepts no new access in the next cycle, so a master that keeps mReq high is served at most every second cycle.
- R11: An entry loaded with tag-register bit 3 clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSel | input | 1 | Register access select |
| cfgWr | input | 1 | Register write when high, read when low |
| cfgAddr | input | 8 | Register byte offset |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data (combinational) |
| mReq | input | 1 | Master request, held until mDone |
| mAddr | input | 32 | Master virtual address |
| mDone | output | 1 | One-cycle completion pulse to the master |
| mErr | output | 1 | Completion carries an error response |
| dValid | output | 1 | One-cycle request to the interconnect |
| dAddr | output | 32 | Translated physical address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the multi-hit fault and the release of a held access after a partial clear. Software never creates duplicate tags through normal random loading. The bench therefore deliberately reloads a slot with a tag that an earlier slot already carries. It then writes only the status bit that is not pending and confirms the master stays held before clearing the real one. Random accesses mix tags drawn from the loaded table with arbitrary tags, so hits, misses and the invalid slot all occur against a bench-side copy of the table. A soft reset in the middle of the run confirms that the flushed entries turn a former hit into a miss.

// File: rtl/sttlb_pkg.sv
package sttlb_pkg;

  localparam logic [7:0] OFF_REV     = 8'h00;
  localparam logic [7:0] OFF_SYSCFG  = 8'h10;
  localparam logic [7:0] OFF_SYSSTAT = 8'h14;
  localparam logic [7:0] OFF_IRQSTAT = 8'h18;
  localparam logic [7:0] OFF_IRQEN   = 8'h1C;
  localparam logic [7:0] OFF_CTRL    = 8'h44;
  localparam logic [7:0] OFF_FAULT   = 8'h48;
  localparam logic [7:0] OFF_LOCK    = 8'h50;
  localparam logic [7:0] OFF_LOAD    = 8'h54;
  localparam logic [7:0] OFF_CAM     = 8'h58;
  localparam logic [7:0] OFF_RAM     = 8'h5C;

  localparam logic [31:0] REV_VALUE = 32'h0000_0020;
  localparam int          PAGE_LSB  = 24;
  localparam int          TAG_W     = 32 - PAGE_LSB;
  localparam int          MAX_IDX_W = 8;

  // strobes from control to the entry store
  typedef struct packed {
    logic                 loadEn;
    logic                 flushAll;
    logic [MAX_IDX_W-1:0] loadIdx;
    logic [TAG_W-1:0]     loadTag;
    logic                 loadValid;
    logic [TAG_W-1:0]     loadBase;
  } tlbCmd_t;

endpackage

// File: rtl/sttlb_dpath.sv
module sttlb_dpath
  import sttlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbCmd_t          cmd,
  input  logic [TAG_W-1:0] lookupTag,
  output logic             hitAny,
  output logic             hitMulti,
  output logic [TAG_W-1:0] hitBase
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  logic [TAG_W-1:0]       tagQ  [NUM_ENTRIES];
  logic [TAG_W-1:0]       baseQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [CNT_W-1:0]       matchCnt;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[gi]   <= '0;
        baseQ[gi]  <= '0;
        validQ[gi] <= 1'b0;
      end else if (cmd.flushAll) begin
        validQ[gi] <= 1'b0;
      end else if (cmd.loadEn && (cmd.loadIdx[IDX_W-1:0] == IDX_W'(gi))) begin
        tagQ[gi]   <= cmd.loadTag;
        baseQ[gi]  <= cmd.loadBase;
        validQ[gi] <= cmd.loadValid;
      end
    end
    assign matchVec[gi] = validQ[gi] && (tagQ[gi] == lookupTag);
  end

  always_comb begin
    hitBase  = '0;
    matchCnt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitBase  = hitBase | baseQ[i];
        matchCnt = matchCnt + CNT_W'(1);
      end
    end
  end

  assign hitAny   = |matchVec;
  assign hitMulti = matchCnt > CNT_W'(1);

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.loadEn && !cmd.flushAll) |->
      validQ[$past(cmd.loadIdx[IDX_W-1:0])] == $past(cmd.loadValid)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.flushAll) |-> (validQ == '0)); // R9
  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (validQ == '0) |-> !hitAny); // R11

endmodule

// File: rtl/sttlb_ctrl.sv
module sttlb_ctrl
  import sttlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int RST_CYCLES  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSel,
  input  logic             cfgWr,
  input  logic [7:0]       cfgAddr,
  input  logic [31:0]      cfgWdata,
  output logic [31:0]      cfgRdata,
  input  logic             mReq,
  input  logic [31:0]      mAddr,
  output logic             mDone,
  output logic             mErr,
  output logic             dValid,
  output logic [31:0]      dAddr,
  output logic             irq,
  output tlbCmd_t          cmd,
  input  logic             hitAny,
  input  logic             hitMulti,
  input  logic [TAG_W-1:0] hitBase
);

  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);

  // status/enable bit 0 = miss, bit 1 = multi-hit (register bits 0 and 4)
  logic [1:0]        irqStatQ, irqEnQ, statSet, statClr;
  logic              xlatOnQ;
  logic [31:0]       faultAddrQ, camQ, ramQ;
  logic [IDX_W-1:0]  lockBaseQ, lockVictQ;
  logic [RCNT_W-1:0] rstCntQ;
  logic              holdQ, mDoneQ, mErrQ, dValidQ;
  logic [31:0]       dAddrQ;

  logic resetting, wrEn, softRstReq, loadReq, accept, fault, release_;

  assign resetting  = rstCntQ != '0;
  assign wrEn       = cfgSel && cfgWr && !resetting;
  assign softRstReq = wrEn && (cfgAddr == OFF_SYSCFG) && cfgWdata[1];
  assign loadReq    = wrEn && (cfgAddr == OFF_LOAD) && cfgWdata[0];
  assign accept     = mReq && !holdQ && !mDoneQ && !resetting && !softRstReq;
  assign fault      = accept && xlatOnQ && (!hitAny || hitMulti);
  assign release_   = holdQ && (irqStatQ == '0);

  assign statSet = {fault && hitMulti, fault && !hitAny};
  assign statClr = (wrEn && (cfgAddr == OFF_IRQSTAT)) ? {cfgWdata[4], cfgWdata[0]} : 2'b00;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStatQ   <= '0;
      irqEnQ     <= '0;
      xlatOnQ    <= 1'b0;
      faultAddrQ <= '0;
      camQ       <= '0;
      ramQ       <= '0;
      lockBaseQ  <= '0;
      lockVictQ  <= '0;
      rstCntQ    <= '0;
    end else if (softRstReq) begin
      irqStatQ   <= '0;
      irqEnQ     <= '0;
      xlatOnQ    <= 1'b0;
      faultAddrQ <= '0;
      camQ       <= '0;
      ramQ       <= '0;
      lockBaseQ  <= '0;
      lockVictQ  <= '0;
      rstCntQ    <= RCNT_W'(RST_CYCLES);
    end else begin
      if (resetting) rstCntQ <= rstCntQ - RCNT_W'(1);
      irqStatQ <= (irqStatQ & ~statClr) | statSet;
      if (fault) faultAddrQ <= mAddr;
      if (wrEn) begin
        case (cfgAddr)
          OFF_IRQEN: irqEnQ  <= {cfgWdata[4], cfgWdata[0]};
          OFF_CTRL:  xlatOnQ <= cfgWdata[1];
          OFF_LOCK: begin
            lockBaseQ <= cfgWdata[10 +: IDX_W];
            lockVictQ <= cfgWdata[4 +: IDX_W];
          end
          OFF_CAM:   camQ <= cfgWdata;
          OFF_RAM:   ramQ <= {cfgWdata[31:20], 20'h0};
          default: ;
        endcase
      end
    end
  end

  // master / downstream sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= 1'b0;
      mDoneQ  <= 1'b0;
      mErrQ   <= 1'b0;
      dValidQ <= 1'b0;
      dAddrQ  <= '0;
    end else begin
      mDoneQ  <= 1'b0;
      mErrQ   <= 1'b0;
      dValidQ <= 1'b0;
      if (accept && !fault) begin
        mDoneQ  <= 1'b1;
        dValidQ <= 1'b1;
        dAddrQ  <= xlatOnQ ? {hitBase, mAddr[PAGE_LSB-1:0]} : mAddr;
      end
      if (fault) holdQ <= 1'b1;
      if (release_) begin
        holdQ  <= 1'b0;
        mDoneQ <= 1'b1;
        mErrQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.loadEn    = loadReq;
    cmd.flushAll  = softRstReq;
    cmd.loadIdx   = MAX_IDX_W'(lockVictQ);
    cmd.loadTag   = camQ[31:PAGE_LSB];
    cmd.loadValid = camQ[3];
    cmd.loadBase  = ramQ[31:PAGE_LSB];
  end

  always_comb begin
    cfgRdata = '0;
    if (cfgSel && !cfgWr) begin
      case (cfgAddr)
        OFF_REV:     cfgRdata = REV_VALUE;
        OFF_SYSSTAT: cfgRdata = {31'h0, resetting};
        OFF_IRQSTAT: cfgRdata = {27'h0, irqStatQ[1], 3'h0, irqStatQ[0]};
        OFF_IRQEN:   cfgRdata = {27'h0, irqEnQ[1], 3'h0, irqEnQ[0]};
        OFF_CTRL:    cfgRdata = {30'h0, xlatOnQ, 1'b0};
        OFF_FAULT:   cfgRdata = faultAddrQ;
        OFF_LOCK:    cfgRdata = (32'(lockBaseQ) << 10) | (32'(lockVictQ) << 4);
        OFF_CAM:     cfgRdata = camQ;
        OFF_RAM:     cfgRdata = ramQ;
        default:     cfgRdata = '0;
      endcase
    end
  end

  assign irq    = |(irqStatQ & irqEnQ);
  assign mDone  = mDoneQ;
  assign mErr   = mErrQ;
  assign dValid = dValidQ;
  assign dAddr  = dAddrQ;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (dValidQ && !$past(xlatOnQ)) |-> (dAddrQ == $past(mAddr))); // R2
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (dValidQ && $past(xlatOnQ)) |-> (dAddrQ[PAGE_LSB-1:0] == $past(mAddr[PAGE_LSB-1:0]))); // R4
  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    holdQ |-> (!dValidQ && !mDoneQ)); // R5
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdQ) |-> (faultAddrQ == $past(mAddr))); // R5
  AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(irqStatQ[0] && irqStatQ[1])); // R6
  AST_RELEASE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdQ) |-> (mDoneQ && mErrQ && !dValidQ)); // R8
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    resetting |-> !dValidQ); // R9
  AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    mDoneQ |=> !mDoneQ); // R10

endmodule

// File: rtl/sttlb_xlat.sv
module sttlb_xlat
  import sttlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int RST_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSel,
  input  logic        cfgWr,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        mReq,
  input  logic [31:0] mAddr,
  output logic        mDone,
  output logic        mErr,
  output logic        dValid,
  output logic [31:0] dAddr,
  output logic        irq
);

  tlbCmd_t          cmd;
  logic             hitAny, hitMulti;
  logic [TAG_W-1:0] hitBase;

  sttlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgSel(cfgSel), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .mReq(mReq), .mAddr(mAddr), .mDone(mDone), .mErr(mErr),
    .dValid(dValid), .dAddr(dAddr), .irq(irq),
    .cmd(cmd), .hitAny(hitAny), .hitMulti(hitMulti), .hitBase(hitBase)
  );

  sttlb_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .lookupTag(mAddr[31:PAGE_LSB]),
    .hitAny(hitAny), .hitMulti(hitMulti), .hitBase(hitBase)
  );

endmodule

// File: tb/sttlb_xlat_bench.sv
module sttlb_xlat_bench;

  localparam int N  = 32;
  localparam int RC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSel = 1'b0, cfgWr = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0, cfgRdata;
  logic        mReq = 1'b0;
  logic [31:0] mAddr = '0;
  logic        mDone, mErr, dValid, irq;
  logic [31:0] dAddr;

  int nRun = 0, nFail = 0;

  logic [7:0] mTag [N];
  logic [7:0] mBase[N];
  bit         mValid[N];

  always #4 clk = ~clk;

  sttlb_xlat #(.NUM_ENTRIES(N), .RST_CYCLES(RC)) u_sttlb_xlat (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWr(cfgWr), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .mReq(mReq), .mAddr(mAddr),
    .mDone(mDone), .mErr(mErr), .dValid(dValid), .dAddr(dAddr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgSel = 1'b1; cfgWr = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgSel = 1'b0; cfgWr = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgSel = 1'b1; cfgWr = 1'b0; cfgAddr = a;
    #1 d = cfgRdata;
    cfgSel = 1'b0;
  endtask

  task automatic loadEntry(input int idx, input logic [7:0] tag, input logic [7:0] base, input bit vld);
    cfgWrite(8'h58, {tag, 20'h0, vld ? 4'hF : 4'h7});
    cfgWrite(8'h5C, {base, 24'h0});
    cfgWrite(8'h50, (32'((idx + 1) % N) << 10) | (32'(idx) << 4));
    cfgWrite(8'h54, 32'h1);
    mTag[idx] = tag; mBase[idx] = base; mValid[idx] = vld;
  endtask

  // returns got=0 with mReq still high if no completion within 8 cycles
  task automatic access(input logic [31:0] a, output bit got, output bit err,
                        output bit sawDv, output logic [31:0] da);
    got = 0; err = 0; sawDv = 0; da = '0;
    @(negedge clk);
    mReq = 1'b1; mAddr = a;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (dValid) sawDv = 1;
      if (mDone) begin
        got = 1; err = mErr; da = dAddr; mReq = 1'b0;
        break;
      end
    end
  endtask

  task automatic waitDone(output bit got, output bit err, output bit sawDv);
    got = 0; err = 0; sawDv = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (dValid) sawDv = 1;
      if (mDone) begin
        got = 1; err = mErr; mReq = 1'b0;
        break;
      end
    end
  endtask

  function automatic int predict(input logic [31:0] a, output logic [31:0] p);
    int h = 0;
    p = a;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mTag[i] == a[31:24]) begin
        h++;
        p = {mBase[i], a[23:0]};
      end
    return h;
  endfunction

  // miss/multi path: expects hold, status, fault address, then clears
  task automatic faultFlow(input string req, input logic [31:0] a, input logic [31:0] expStat);
    bit got, err, dv;
    logic [31:0] da, rd;
    access(a, got, err, dv, da);
    chk({req, " held no mDone"}, 32'(got), 32'(0));
    chk({req, " held no dValid"}, 32'(dv), 32'(0));
    cfgRead(8'h18, rd); chk({req, " status"}, rd, expStat);
    cfgRead(8'h48, rd); chk({req, " fault address"}, rd, a);
    cfgWrite(8'h18, expStat);
    waitDone(got, err, dv);
    chk("R8 release done", 32'(got), 32'(1));
    chk("R8 release err", 32'(err), 32'(1));
    chk("R8 release no dValid", 32'(dv), 32'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit got, err, dv;
    logic [31:0] da, rd, p, a;
    int h, cnt;
    void'($urandom(32'h5A17));
    for (int i = 0; i < N; i++) begin mTag[i] = '0; mBase[i] = '0; mValid[i] = 0; end

    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    cfgRead(8'h00, rd); chk("R1 revision", rd, 32'h20);
    cfgRead(8'h44, rd); chk("R1 control", rd, 32'h0);
    cfgRead(8'h18, rd); chk("R1 status", rd, 32'h0);
    cfgRead(8'h48, rd); chk("R1 fault", rd, 32'h0);
    cfgRead(8'h14, rd); chk("R1 sysstatus", rd, 32'h0);
    chk("R1 irq", 32'(irq), 32'(0));
    cfgWrite(8'h00, 32'hFFFF_FFFF);
    cfgRead(8'h00, rd); chk("R1 revision write ignored", rd, 32'h20);

    // R2 pass-through
    for (int k = 0; k < 6; k++) begin
      a = $urandom;
      access(a, got, err, dv, da);
      chk("R2 done", 32'(got && !err && dv), 32'(1));
      chk("R2 address", da, a);
    end

    // R3 loading, entry 7 invalid (R11)
    for (int i = 0; i < N; i++)
      loadEntry(i, 8'((i * 37 + 5) & 8'hFF), 8'($urandom), i != 7);
    cfgRead(8'h58, rd); chk("R3 tag readback", rd, {mTag[N-1], 20'h0, 4'hF});
    cfgRead(8'h5C, rd); chk("R3 base readback", rd, {mBase[N-1], 24'h0});
    cfgRead(8'h50, rd); chk("R3 lock readback", rd, (32'(0) << 10) | (32'(N - 1) << 4));
    cfgWrite(8'h5C, 32'hABCD_EF12);
    cfgRead(8'h5C, rd); chk("R3 base register keeps [31:20]", rd, 32'hABC0_0000);
    cfgWrite(8'h1C, 32'h11);
    cfgWrite(8'h44, 32'h2);

    // R4 directed hit
    a = {mTag[0], 24'h123456};
    access(a, got, err, dv, da);
    chk("R4 hit done", 32'(got && !err && dv), 32'(1));
    chk("R4 hit address", da, {mBase[0], 24'h123456});

    // random mix of hits and misses
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 3) != 0) a = {mTag[$urandom_range(0, N - 1)], 24'($urandom)};
      else a = $urandom;
      h = predict(a, p);
      if (h == 1) begin
        access(a, got, err, dv, da);
        chk("R4 random hit done", 32'(got && !err && dv), 32'(1));
        chk("R4 random hit address", da, p);
      end else begin
        faultFlow("R5 random miss", a, 32'h1);
      end
    end

    // R11 invalid entry never matches
    faultFlow("R11 invalid entry miss", {mTag[7], 24'h000777}, 32'h1);

    // R7 masking and R8 partial clear keeps the hold
    cfgWrite(8'h1C, 32'h0);
    a = {mTag[7], 24'h00ABCD};
    access(a, got, err, dv, da);
    chk("R7 irq masked", 32'(irq), 32'(0));
    cfgWrite(8'h1C, 32'h10);
    chk("R7 irq other bit enabled", 32'(irq), 32'(0));
    cfgWrite(8'h1C, 32'h01);
    chk("R7 irq enabled", 32'(irq), 32'(1));
    cfgWrite(8'h18, 32'h10);
    waitDone(got, err, dv);
    chk("R8 partial clear still held", 32'(got), 32'(0));
    cfgRead(8'h18, rd); chk("R8 status kept", rd, 32'h1);
    cfgWrite(8'h18, 32'h1);
    waitDone(got, err, dv);
    chk("R8 full clear releases", 32'(got && err && !dv), 32'(1));
    chk("R7 irq low after clear", 32'(irq), 32'(0));
    cfgWrite(8'h1C, 32'h11);

    // R6 multi-hit
    loadEntry(N - 1, mTag[0], 8'h3C, 1);
    a = {mTag[0], 24'h00F00D};
    access(a, got, err, dv, da);
    chk("R6 multi held", 32'(got), 32'(0));
    cfgRead(8'h18, rd); chk("R6 multi status", rd, 32'h10);
    chk("R7 irq on multi", 32'(irq), 32'(1));
    cfgWrite(8'h18, 32'h10);
    waitDone(got, err, dv);
    chk("R6 multi error completion", 32'(got && err && !dv), 32'(1));

    // R10 spacing with mReq held high
    a = {mTag[1], 24'h000111};
    access(a, got, err, dv, da);
    @(negedge clk);
    mReq = 1'b1; mAddr = {mTag[2], 24'h000222};
    @(negedge clk);
    chk("R10 first served", 32'(mDone), 32'(1));
    chk("R10 first address", dAddr, {mBase[2], 24'h000222});
    mAddr = {mTag[3], 24'h000333};
    @(negedge clk);
    chk("R10 gap cycle", 32'(mDone), 32'(0));
    @(negedge clk);
    chk("R10 second served", 32'(mDone), 32'(1));
    chk("R10 second address", dAddr, {mBase[3], 24'h000333});
    mReq = 1'b0;

    // R9 soft reset
    cfgWrite(8'h10, 32'h2);
    cnt = 0;
    for (int k = 0; k < RC + 3; k++) begin
      cfgSel = 1'b1; cfgWr = 1'b0; cfgAddr = 8'h14;
      #1 if (cfgRdata[0]) cnt++;
      cfgSel = 1'b0;
      @(negedge clk);
    end
    chk("R9 busy cycles", 32'(cnt), 32'(RC));
    cfgRead(8'h44, rd); chk("R9 control cleared", rd, 32'h0);
    cfgRead(8'h1C, rd); chk("R9 enable cleared", rd, 32'h0);
    cfgRead(8'h58, rd); chk("R9 tag register cleared", rd, 32'h0);
    for (int i = 0; i < N; i++) mValid[i] = 0;
    cfgWrite(8'h44, 32'h2);
    faultFlow("R9 flushed entry misses", {mTag[0], 24'h000042}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule